// File: doc/BRIEF.md
# Windowed Framebuffer Address Generator

This block produces write addresses for a packed frame memory that holds two 4-bit pixels per byte, organised as 64 byte-columns by 80 rows. It keeps a column pointer and a row pointer that move inside a rectangular window. The window is loaded per axis from decoded command values, and each bound is reduced modulo the size of its axis. Loading an axis also places that axis's pointer at the new start.

Each data-write strobe sends one byte to the memory at `row*64 + col`. The write is registered and presented with a one-cycle enable. The pointers then advance inside the window. In horizontal order the column moves first and carries into the row. In vertical order the row moves first and carries into the column. A redraw-pending flag is raised by every write and is cleared when a display readout pass completes. Serial reception and command decoding happen upstream. This block only sees the decoded window values, the order bit, the strobe and the pass-done pulse.

Top module: `fb_window_addr`

## Requirements
- R1: After reset the column window is 0..63, the row window is 0..79, both pointers are 0, `redraw_pend` is 0 and `mem_we` is 0.
- R2: A `col_load` pulse sets the column start to `col_lo_in mod 64` and the column end to `col_hi_in mod 64`. The column pointer equals the new start in the following cycle.
- R3: A `row_load` pulse sets the row start to `row_lo_in mod 80` and the row end to `row_hi_in mod 80`. The row pointer equals the new start in the following cycle.
- R4: Each cycle with `wr_stb` high produces exactly one cycle of `mem_we` in the next cycle. In that cycle `mem_addr` equals `row*64 + col`, taken from the pointers as they stood at the strobe, and `mem_wdata` equals the strobed `wr_data`. `mem_we` is low in every other cycle.
- R5: With `vert_mode` = 0 (horizontal), a write advances the column. A column at or past its end returns to the column start, and the row then advances. A row at or past its end returns to the row start.
- R6: With `vert_mode` = 1 (vertical), a write advances the row. A row at or past its end returns to the row start, and the column then advances. A column at or past its end returns to the column start.
- R7: When a start exceeds its end, every advance on that axis returns the pointer to the start and carries into the other axis.
- R8: Strobes on consecutive cycles are each written and each advance the pointers once. With no strobe and no load, the pointers hold.
- R9: A write sets `redraw_pend` and a `scan_done` pulse clears it. When both occur in the same cycle, the flag is set.
- R10: When a window load coincides with a strobe, the write uses the old pointers and the load sets the pointers. Neither pointer advances for that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_load | input | 1 | Load column window |
| col_lo_in | input | 8 | Column window start (before reduction) |
| col_hi_in | input | 8 | Column window end (before reduction) |
| row_load | input | 1 | Load row window |
| row_lo_in | input | 8 | Row window start (before reduction) |
| row_hi_in | input | 8 | Row window end (before reduction) |
| vert_mode | input | 1 | 0 = column-first order, 1 = row-first order |
| wr_stb | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte (two pixels) |
| scan_done | input | 1 | Readout pass finished, clears redraw flag |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 13 | Frame memory byte address |
| mem_wdata | output | 8 | Frame memory write data |
| cur_col | output | 6 | Current column pointer |
| cur_row | output | 7 | Current row pointer |
| redraw_pend | output | 1 | Frame changed since the last readout pass |

## Verification
The bound checker checks the following every cycle: the one-cycle write enable and its address and data relative to the pointers one cycle earlier, the modulo reduction on each window load, pointer range, pointer hold when idle, and the redraw flag's set and clear. The traversal order cannot be expressed as a simple property. This covers the carry from one axis into the other, wrapping at window edges, inverted windows, the reset-time full window and the priority of a load over an advance. The bench's directed scenarios show these by comparing every write beat against its own pointer model.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
   typedef enum logic {
      ORD_COL_FIRST = 1'b0,
      ORD_ROW_FIRST = 1'b1
   } scan_order_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/fbw_mod_reduce.sv
module fbw_mod_reduce #(
   parameter int IN_W  = 8,
   parameter int COUNT = 80,
   parameter int OUT_W = 7
) (
   input  logic [IN_W-1:0]  raw_val,
   output logic [OUT_W-1:0] red_val
);
   generate
      if (IN_W < OUT_W) begin : g_bad_width
         $error("fbw_mod_reduce: input narrower than output");
      end
      if (fbw_pkg::is_pow2(COUNT)) begin : g_mask
         assign red_val = raw_val[OUT_W-1:0];
      end else begin : g_modulo
         logic [31:0] rem;
         assign rem     = 32'(raw_val) % 32'(COUNT);
         assign red_val = rem[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fbw_axis.sv
module fbw_axis #(
   parameter int PTR_W = 6,
   parameter int LAST  = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] lo_in,
   input  logic [PTR_W-1:0] hi_in,
   input  logic             step,
   output logic [PTR_W-1:0] ptr,
   output logic             at_end
);
   logic [PTR_W-1:0] lo_q;
   logic [PTR_W-1:0] hi_q;

   assign at_end = (ptr >= hi_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= PTR_W'(LAST);
         ptr  <= '0;
      end else if (load) begin
         lo_q <= lo_in;
         hi_q <= hi_in;
         ptr  <= lo_in;
      end else if (step) begin
         ptr <= at_end ? lo_q : ptr + PTR_W'(1);
      end
   end
endmodule

// File: rtl/fbw_wr_port.sv
module fbw_wr_port #(
   parameter int COL_COUNT = 64,
   parameter int COL_W     = 6,
   parameter int ROW_W     = 7,
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [COL_W-1:0]  col,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] data,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   logic [ADDR_W-1:0] addr_c;

   generate
      if (fbw_pkg::is_pow2(COL_COUNT)) begin : g_concat
         logic [ROW_W+COL_W-1:0] joined;
         assign joined = {row, col};
         assign addr_c = joined[ADDR_W-1:0];
      end else begin : g_mult
         assign addr_c = ADDR_W'(row) * ADDR_W'(COL_COUNT) + ADDR_W'(col);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we    <= 1'b0;
         addr  <= '0;
         wdata <= '0;
      end else begin
         we <= stb;
         if (stb) begin
            addr  <= addr_c;
            wdata <= data;
         end
      end
   end
endmodule

// File: rtl/fb_window_addr.sv
module fb_window_addr #(
   parameter int COL_COUNT = 64,
   parameter int ROW_COUNT = 80,
   parameter int IN_W      = 8,
   parameter int DATA_W    = 8,
   localparam int COL_W    = $clog2(COL_COUNT),
   localparam int ROW_W    = $clog2(ROW_COUNT),
   localparam int ADDR_W   = $clog2(COL_COUNT * ROW_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_load,
   input  logic [IN_W-1:0]   col_lo_in,
   input  logic [IN_W-1:0]   col_hi_in,
   input  logic              row_load,
   input  logic [IN_W-1:0]   row_lo_in,
   input  logic [IN_W-1:0]   row_hi_in,
   input  logic              vert_mode,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              scan_done,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [COL_W-1:0]  cur_col,
   output logic [ROW_W-1:0]  cur_row,
   output logic              redraw_pend
);
   import fbw_pkg::*;

   generate
      if (COL_COUNT < 2 || ROW_COUNT < 2) begin : g_bad_dims
         $error("fb_window_addr: each axis needs at least two positions");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("fb_window_addr: DATA_W must be positive");
      end
   endgenerate

   logic [COL_W-1:0] col_lo_r, col_hi_r;
   logic [ROW_W-1:0] row_lo_r, row_hi_r;
   logic             col_at_end, row_at_end;
   logic             adv, col_step, row_step;
   scan_order_e      order;

   fbw_mod_reduce #(.IN_W(IN_W), .COUNT(COL_COUNT), .OUT_W(COL_W)) u_red_col_lo (
      .raw_val(col_lo_in), .red_val(col_lo_r));
   fbw_mod_reduce #(.IN_W(IN_W), .COUNT(COL_COUNT), .OUT_W(COL_W)) u_red_col_hi (
      .raw_val(col_hi_in), .red_val(col_hi_r));
   fbw_mod_reduce #(.IN_W(IN_W), .COUNT(ROW_COUNT), .OUT_W(ROW_W)) u_red_row_lo (
      .raw_val(row_lo_in), .red_val(row_lo_r));
   fbw_mod_reduce #(.IN_W(IN_W), .COUNT(ROW_COUNT), .OUT_W(ROW_W)) u_red_row_hi (
      .raw_val(row_hi_in), .red_val(row_hi_r));

   // A load in the same cycle as a write suppresses the advance.
   assign order = scan_order_e'(vert_mode);
   assign adv   = wr_stb & ~col_load & ~row_load;

   always_comb begin
      if (order == ORD_ROW_FIRST) begin
         row_step = adv;
         col_step = adv & row_at_end;
      end else begin
         col_step = adv;
         row_step = adv & col_at_end;
      end
   end

   fbw_axis #(.PTR_W(COL_W), .LAST(COL_COUNT - 1)) u_col_axis (
      .clk(clk), .rst_n(rst_n), .load(col_load), .lo_in(col_lo_r),
      .hi_in(col_hi_r), .step(col_step), .ptr(cur_col), .at_end(col_at_end));

   fbw_axis #(.PTR_W(ROW_W), .LAST(ROW_COUNT - 1)) u_row_axis (
      .clk(clk), .rst_n(rst_n), .load(row_load), .lo_in(row_lo_r),
      .hi_in(row_hi_r), .step(row_step), .ptr(cur_row), .at_end(row_at_end));

   fbw_wr_port #(
      .COL_COUNT(COL_COUNT), .COL_W(COL_W), .ROW_W(ROW_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_wr_port (
      .clk(clk), .rst_n(rst_n), .stb(wr_stb), .col(cur_col), .row(cur_row),
      .data(wr_data), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata));

   // A new write wins over a completed readout pass.
   always_ff @(posedge clk) begin
      if (!rst_n)         redraw_pend <= 1'b0;
      else if (wr_stb)    redraw_pend <= 1'b1;
      else if (scan_done) redraw_pend <= 1'b0;
   end
endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
   parameter int COL_COUNT = 64,
   parameter int ROW_COUNT = 80,
   parameter int IN_W      = 8,
   parameter int DATA_W    = 8,
   localparam int COL_W    = $clog2(COL_COUNT),
   localparam int ROW_W    = $clog2(ROW_COUNT),
   localparam int ADDR_W   = $clog2(COL_COUNT * ROW_COUNT)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              col_load,
   input logic [IN_W-1:0]   col_lo_in,
   input logic              row_load,
   input logic [IN_W-1:0]   row_lo_in,
   input logic              wr_stb,
   input logic [DATA_W-1:0] wr_data,
   input logic              scan_done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [COL_W-1:0]  cur_col,
   input logic [ROW_W-1:0]  cur_row,
   input logic              redraw_pend
);
   p_we_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> mem_we);
   p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> !mem_we);
   p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (int'(mem_addr) ==
                  int'($past(cur_row)) * COL_COUNT + int'($past(cur_col))));
   p_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (mem_wdata == $past(wr_data)));
   p_col_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_load |=> (int'(cur_col) == int'($past(col_lo_in)) % COL_COUNT));
   p_row_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      row_load |=> (int'(cur_row) == int'($past(row_lo_in)) % ROW_COUNT));
   p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_col) < COL_COUNT);
   p_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_row) < ROW_COUNT);
   p_col_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !col_load) |=> $stable(cur_col));
   p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !row_load) |=> $stable(cur_row));
   p_redraw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> redraw_pend);
   p_redraw_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !wr_stb) |=> !redraw_pend);
endmodule

bind fb_window_addr fbw_checker #(
   .COL_COUNT(COL_COUNT), .ROW_COUNT(ROW_COUNT), .IN_W(IN_W), .DATA_W(DATA_W)
) u_fbw_checker (.*);

// File: tb/fb_window_addr_bench.sv
`timescale 1ns/1ps
module fb_window_addr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        col_load = 1'b0, row_load = 1'b0;
   logic [7:0]  col_lo_in = '0, col_hi_in = '0, row_lo_in = '0, row_hi_in = '0;
   logic        vert_mode = 1'b0, wr_stb = 1'b0, scan_done = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        mem_we;
   logic [12:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [5:0]  cur_col;
   logic [6:0]  cur_row;
   logic        redraw_pend;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_cs, m_ce, m_rs, m_re, m_c, m_r;

   always #4 clk = ~clk;

   fb_window_addr u_fb_window_addr (.*);

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79; m_c = 0; m_r = 0;
   endtask

   task automatic model_step(input bit v);
      if (!v) begin
         if (m_c >= m_ce) begin
            m_c = m_cs;
            if (m_r >= m_re) m_r = m_rs; else m_r++;
         end else m_c++;
      end else begin
         if (m_r >= m_re) begin
            m_r = m_rs;
            if (m_c >= m_ce) m_c = m_cs; else m_c++;
         end else m_r++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic load_win(input bit is_col, input int lo, input int hi, input string req);
      @(negedge clk);
      if (is_col) begin col_load = 1'b1; col_lo_in = 8'(lo); col_hi_in = 8'(hi); end
      else        begin row_load = 1'b1; row_lo_in = 8'(lo); row_hi_in = 8'(hi); end
      @(negedge clk);
      col_load = 1'b0; row_load = 1'b0;
      if (is_col) begin m_cs = lo % 64; m_ce = hi % 64; m_c = m_cs;
         chk(req, "col after load", int'(cur_col), m_c);
      end else begin m_rs = lo % 80; m_re = hi % 80; m_r = m_rs;
         chk(req, "row after load", int'(cur_row), m_r);
      end
   endtask

   // Back-to-back strobes; each beat checked one cycle after its strobe.
   task automatic burst(input int n, input bit v, input int base, input string req);
      int exp_addr;
      @(negedge clk);
      vert_mode = v; wr_stb = 1'b1; wr_data = 8'(base);
      for (int i = 0; i < n; i++) begin
         exp_addr = m_r * 64 + m_c;
         model_step(v);
         @(negedge clk);
         chk(req, "we", int'(mem_we), 1);
         chk(req, "addr", int'(mem_addr), exp_addr);
         chk(req, "wdata", int'(mem_wdata), (base + i) & 8'hFF);
         chk(req, "col", int'(cur_col), m_c);
         chk(req, "row", int'(cur_row), m_r);
         if (i == n - 1) wr_stb = 1'b0; else wr_data = 8'(base + i + 1);
      end
      @(negedge clk);
      chk("R4", "we drops", int'(mem_we), 0);
      chk("R8", "col hold", int'(cur_col), m_c);
      chk("R8", "row hold", int'(cur_row), m_r);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "col", int'(cur_col), 0);
      chk("R1", "row", int'(cur_row), 0);
      chk("R1", "redraw", int'(redraw_pend), 0);
      chk("R1", "we", int'(mem_we), 0);
      burst(66, 1'b0, 8'h10, "R1");   // column end 63 at reset
      do_reset();
      burst(82, 1'b1, 8'h40, "R1");   // row end 79 at reset
   endtask

   task automatic t_horizontal();
      do_reset();
      load_win(1'b1, 70, 200, "R2");  // 6..8
      load_win(1'b0, 85, 250, "R3");  // 5..10
      burst(20, 1'b0, 8'hA0, "R5");
   endtask

   task automatic t_vertical();
      load_win(1'b1, 2, 4, "R2");
      load_win(1'b0, 77, 159, "R3");  // 77..79
      burst(12, 1'b1, 8'h33, "R6");
   endtask

   task automatic t_inverted();
      load_win(1'b1, 10, 3, "R7");
      load_win(1'b0, 0, 79, "R7");
      burst(3, 1'b0, 8'h77, "R7");
      load_win(1'b0, 50, 20, "R7");
      burst(3, 1'b1, 8'h88, "R7");
   endtask

   task automatic t_redraw();
      @(negedge clk); scan_done = 1'b1;
      @(negedge clk); scan_done = 1'b0;
      chk("R9", "cleared", int'(redraw_pend), 0);
      @(negedge clk); scan_done = 1'b1; wr_stb = 1'b1; wr_data = 8'h5A;
      model_step(vert_mode);
      @(negedge clk); scan_done = 1'b0; wr_stb = 1'b0;
      chk("R9", "set wins", int'(redraw_pend), 1);
   endtask

   task automatic t_load_priority();
      int old_addr;
      load_win(1'b1, 0, 63, "R10");
      load_win(1'b0, 0, 79, "R10");
      burst(5, 1'b0, 8'h01, "R10");
      old_addr = m_r * 64 + m_c;
      @(negedge clk);
      vert_mode = 1'b0; wr_stb = 1'b1; wr_data = 8'hC3;
      col_load = 1'b1; col_lo_in = 8'd20; col_hi_in = 8'd30;
      @(negedge clk);
      wr_stb = 1'b0; col_load = 1'b0;
      chk("R10", "we", int'(mem_we), 1);
      chk("R10", "old addr", int'(mem_addr), old_addr);
      chk("R10", "col = new start", int'(cur_col), 20);
      chk("R10", "row no advance", int'(cur_row), m_r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      t_reset();
      t_horizontal();
      t_vertical();
      t_inverted();
      t_redraw();
      t_load_priority();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule